// File: doc/BRIEF.md
# Scanline-Timed Repeating Interrupt Generator

This block produces a peripheral interrupt at a programmed position on the screen. After that it repeats the interrupt once per scanline for a programmed number of times, which is the timing a light-gun style input produces. It observes a free-running cycle counter and a frame-start strobe, and it keeps the counter value of the latest frame start as its time base. An arm command carries a repeat count, a line number and a signed horizontal cycle offset. A mode input selects the 60 Hz or the 50 Hz video standard.

On arm, the block latches the command and the current frame base. It then computes the line offset `y * frame_period / lines_per_frame` in a short sequential divider. The first event is placed one whole frame after the latched frame base, plus that line offset, plus the horizontal offset. Each firing sets the interrupt flag. Each later firing is scheduled one line period after the previous scheduled time, not after the time software serviced the flag. Frame and line periods are elaboration-time constants derived from the clock rate parameter.

Top module: `scan_irq_gen`

## Requirements
- R1: After reset the status output is zero, `busy_o` is low and `err_o` is low.
- R2: In 60 Hz mode (`std50_i` = 0) the frame period is F = CLK_HZ/60 and a frame has 263 lines. The first firing sets bit 10 of `irq_stat_o` at the clock edge where `cycle_i` equals B + F + floor(y*F/263) + x. B is the `cycle_i` value captured with the last `frame_start_i` pulse at or before the arm.
- R3: In 50 Hz mode (`std50_i` = 1) the same rule applies with F = CLK_HZ/50 and 314 lines.
- R4: A count N > 1 gives N firings. Firing k (k from 0) is due at T0 + k*L, where L = floor(F/lines). `busy_o` rises on the edge after the arm and is low once the last firing is done.
- R5: A repeat count of 0 or 1 gives exactly one firing.
- R6: An arm while a sequence is active cancels it, and no further firing of the old sequence occurs. The new parameters then apply from the current frame base.
- R7: Only bit 10 of `irq_stat_o` can ever be 1. Once set, the bit stays set until a write (`ack_we_i` = 1) with bit 10 of `ack_data_i` equal to 0 clears it. A write with bit 10 = 1 has no effect.
- R8: When a firing and a clearing write fall on the same edge, the bit ends up set.
- R9: If the first event time would fall before the latched frame base (F + line offset + x < 0), `err_o` pulses for exactly one cycle, no firing occurs and `busy_o` is low.
- R10: The mode, count, line and offset are sampled only with `arm_i`. Later changes on those inputs do not alter a running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_i | input | TW | Free-running cycle counter |
| frame_start_i | input | 1 | Frame-start strobe; captures `cycle_i` as frame base |
| std50_i | input | 1 | Video standard: 0 = 60 Hz, 1 = 50 Hz |
| arm_i | input | 1 | Arm command strobe |
| arm_count_i | input | CNT_W | Number of firings (0 treated as 1) |
| arm_line_i | input | Y_W | Target line number y |
| arm_xoff_i | input | X_W | Signed horizontal cycle offset x |
| ack_we_i | input | 1 | Status write strobe |
| ack_data_i | input | STAT_W | Status write data; 0 at bit 10 clears the flag |
| irq_stat_o | output | STAT_W | Interrupt status, flag at bit 10 |
| busy_o | output | 1 | A sequence is being computed or is pending |
| err_o | output | 1 | One-cycle pulse on an illegal first event time |

## Verification
A firing due at counter value T sets the flag on the same edge at which `cycle_i` equals T. No register lies between the time compare and the status flag. The bench advances its counter just after each rising edge and samples on the falling edge. It therefore records the counter value minus one as the firing time and compares that with the formula exactly. The busy flag is due one edge after an arm, and the result of a write is due one edge after the write. Both are checked at the next falling edge. The error pulse follows the arm by the divider latency, so it is checked within a fixed window of 80 cycles, together with its one-cycle width.

// File: rtl/scan_irq_pkg.sv
package scan_irq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DIV,
    ST_WAIT
  } sched_st_e;
endpackage

// File: rtl/scan_irq_div.sv
// Restoring divider, one quotient bit per cycle.
module scan_irq_div #(
  parameter int unsigned NUM_W = 41,
  parameter int unsigned DEN_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int unsigned CW = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] acc_q;
  logic [DEN_W-1:0] rem_q, den_q;
  logic [CW-1:0]    cnt_q;
  logic             done_q;
  logic [DEN_W:0]   trial, trial_sub;
  logic             ge;

  always_comb begin
    trial     = {rem_q, acc_q[NUM_W-1]};
    ge        = (trial >= {1'b0, den_q});
    trial_sub = trial - {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (start_i) begin
      acc_q  <= num_i;
      rem_q  <= '0;
      den_q  <= den_i;
      cnt_q  <= CW'(NUM_W);
      done_q <= 1'b0;
    end else if (cnt_q != '0) begin
      acc_q  <= {acc_q[NUM_W-2:0], ge};
      rem_q  <= ge ? trial_sub[DEN_W-1:0] : trial[DEN_W-1:0];
      cnt_q  <= cnt_q - 1'b1;
      done_q <= (cnt_q == CW'(1));
    end else begin
      done_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign quo_o  = acc_q;
endmodule

// File: rtl/scan_irq_sched.sv
module scan_irq_sched
  import scan_irq_pkg::*;
#(
  parameter int unsigned TW      = 32,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned Y_W     = 9,
  parameter int unsigned X_W     = 16,
  parameter int unsigned FRAME_A = 5260,
  parameter int unsigned FRAME_B = 6312,
  parameter int unsigned LINES_A = 263,
  parameter int unsigned LINES_B = 314
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [TW-1:0]        cycle_i,
  input  logic [TW-1:0]        base_i,
  input  logic                 arm_i,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic [Y_W-1:0]       y_i,
  input  logic signed [X_W-1:0] x_i,
  input  logic                 std50_i,
  output logic                 fire_o,
  output logic                 busy_o,
  output logic                 err_o
);
  localparam int unsigned LINE_A = FRAME_A / LINES_A;
  localparam int unsigned LINE_B = FRAME_B / LINES_B;
  localparam int unsigned LMAX   = (LINES_A > LINES_B) ? LINES_A : LINES_B;
  localparam int unsigned LW     = $clog2(LMAX + 1);
  localparam int unsigned PROD_W = TW + Y_W;
  localparam int unsigned OFF_W  = TW + 2;

  sched_st_e               st_q;
  logic                    std50_q, err_q;
  logic [CNT_W-1:0]        rem_q;
  logic signed [X_W-1:0]   x_q;
  logic [TW-1:0]           base_q, tgt_q, diff, frame_sel, line_sel;
  logic [PROD_W-1:0]       div_num, div_quo;
  logic [LW-1:0]           div_den;
  logic                    div_done, hit;
  logic signed [OFF_W-1:0] off;

  // divider operands follow the live mode input, sampled on arm
  always_comb begin
    div_num = PROD_W'(y_i) * (std50_i ? PROD_W'(FRAME_B) : PROD_W'(FRAME_A));
    div_den = std50_i ? LW'(LINES_B) : LW'(LINES_A);
  end

  scan_irq_div #(
    .NUM_W(PROD_W),
    .DEN_W(LW)
  ) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(arm_i),
    .num_i  (div_num),
    .den_i  (div_den),
    .done_o (div_done),
    .quo_o  (div_quo)
  );

  always_comb begin
    frame_sel = std50_q ? TW'(FRAME_B) : TW'(FRAME_A);
    line_sel  = std50_q ? TW'(LINE_B) : TW'(LINE_A);
    off = $signed({2'b00, frame_sel}) + $signed(OFF_W'(div_quo))
        + $signed({{(OFF_W-X_W){x_q[X_W-1]}}, x_q});
    diff   = cycle_i - tgt_q;
    hit    = (st_q == ST_WAIT) && !diff[TW-1];
    fire_o = hit && !arm_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      std50_q <= 1'b0;
      rem_q   <= '0;
      x_q     <= '0;
      base_q  <= '0;
      tgt_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (arm_i) begin
        st_q    <= ST_DIV;
        std50_q <= std50_i;
        rem_q   <= (cnt_i == '0) ? CNT_W'(1) : cnt_i;
        x_q     <= x_i;
        base_q  <= base_i;
      end else begin
        unique case (st_q)
          ST_DIV: if (div_done) begin
            if (off[OFF_W-1]) begin
              err_q <= 1'b1;
              st_q  <= ST_IDLE;
            end else begin
              tgt_q <= base_q + off[TW-1:0];
              st_q  <= ST_WAIT;
            end
          end
          ST_WAIT: if (hit) begin
            if (rem_q > CNT_W'(1)) begin
              tgt_q <= tgt_q + line_sel;  // from scheduled time, not service time
              rem_q <= rem_q - 1'b1;
            end else begin
              st_q <= ST_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign busy_o = (st_q != ST_IDLE);
  assign err_o  = err_q;
endmodule

// File: rtl/scan_irq_stat.sv
module scan_irq_stat #(
  parameter int unsigned STAT_W  = 16,
  parameter int unsigned IRQ_BIT = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_i,
  input  logic              ack_we_i,
  input  logic [STAT_W-1:0] ack_data_i,
  output logic [STAT_W-1:0] stat_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                flag_q <= 1'b0;
    else if (set_i)                             flag_q <= 1'b1;
    else if (ack_we_i && !ack_data_i[IRQ_BIT])  flag_q <= 1'b0;
  end

  for (genvar g = 0; g < STAT_W; g++) begin : g_bit
    if (g == IRQ_BIT) begin : g_flag
      assign stat_o[g] = flag_q;
    end else begin : g_zero
      assign stat_o[g] = 1'b0;
    end
  end
endmodule

// File: rtl/scan_irq_gen.sv
module scan_irq_gen #(
  parameter int unsigned CLK_HZ  = 315600,
  parameter int unsigned RATE_A  = 60,
  parameter int unsigned RATE_B  = 50,
  parameter int unsigned LINES_A = 263,
  parameter int unsigned LINES_B = 314,
  parameter int unsigned TW      = 32,
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned Y_W     = 9,
  parameter int unsigned X_W     = 16,
  parameter int unsigned STAT_W  = 16,
  parameter int unsigned IRQ_BIT = 10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [TW-1:0]         cycle_i,
  input  logic                  frame_start_i,
  input  logic                  std50_i,
  input  logic                  arm_i,
  input  logic [CNT_W-1:0]      arm_count_i,
  input  logic [Y_W-1:0]        arm_line_i,
  input  logic signed [X_W-1:0] arm_xoff_i,
  input  logic                  ack_we_i,
  input  logic [STAT_W-1:0]     ack_data_i,
  output logic [STAT_W-1:0]     irq_stat_o,
  output logic                  busy_o,
  output logic                  err_o
);
  localparam int unsigned FRAME_A = CLK_HZ / RATE_A;
  localparam int unsigned FRAME_B = CLK_HZ / RATE_B;

  logic [TW-1:0] base_q, base_now;
  logic          fire_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            base_q <= '0;
    else if (frame_start_i) base_q <= cycle_i;
  end

  assign base_now = frame_start_i ? cycle_i : base_q;

  scan_irq_sched #(
    .TW(TW), .CNT_W(CNT_W), .Y_W(Y_W), .X_W(X_W),
    .FRAME_A(FRAME_A), .FRAME_B(FRAME_B),
    .LINES_A(LINES_A), .LINES_B(LINES_B)
  ) u_sched (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cycle_i(cycle_i),
    .base_i (base_now),
    .arm_i  (arm_i),
    .cnt_i  (arm_count_i),
    .y_i    (arm_line_i),
    .x_i    (arm_xoff_i),
    .std50_i(std50_i),
    .fire_o (fire_w),
    .busy_o (busy_o),
    .err_o  (err_o)
  );

  scan_irq_stat #(
    .STAT_W(STAT_W),
    .IRQ_BIT(IRQ_BIT)
  ) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (fire_w),
    .ack_we_i  (ack_we_i),
    .ack_data_i(ack_data_i),
    .stat_o    (irq_stat_o)
  );
endmodule

// File: rtl/scan_irq_gen_chk.sv
module scan_irq_gen_chk #(
  parameter int unsigned STAT_W  = 16,
  parameter int unsigned IRQ_BIT = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fire_i,
  input logic              busy_i,
  input logic              err_i,
  input logic              arm_i,
  input logic              ack_we_i,
  input logic [STAT_W-1:0] ack_data_i,
  input logic [STAT_W-1:0] stat_i
);
  localparam logic [STAT_W-1:0] FLAG_M = STAT_W'(1) << IRQ_BIT;

  a_r7_other_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_i & ~FLAG_M) == '0);

  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_i[IRQ_BIT] && !(ack_we_i && !ack_data_i[IRQ_BIT]) |=> stat_i[IRQ_BIT]);

  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fire_i && ack_we_i && !ack_data_i[IRQ_BIT] |=> !stat_i[IRQ_BIT]);

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> stat_i[IRQ_BIT]);

  a_r4_fire_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |-> busy_i);

  a_r6_arm_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> busy_i);

  a_r9_err_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |=> !err_i);

  a_r9_err_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> !busy_i);
endmodule

bind scan_irq_gen scan_irq_gen_chk #(
  .STAT_W(STAT_W),
  .IRQ_BIT(IRQ_BIT)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .fire_i    (fire_w),
  .busy_i    (busy_o),
  .err_i     (err_o),
  .arm_i     (arm_i),
  .ack_we_i  (ack_we_i),
  .ack_data_i(ack_data_i),
  .stat_i    (irq_stat_o)
);

// File: tb/test_scan_irq_gen.sv
`timescale 1ns/1ps
module test_scan_irq_gen;
  localparam int CLK_HZ = 315600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cyc = 32'd0;
  logic        frame_start = 1'b0, std50 = 1'b0, arm = 1'b0;
  logic [7:0]  arm_count = '0;
  logic [8:0]  arm_line = '0;
  logic signed [15:0] arm_xoff = '0;
  logic        ack_we = 1'b0;
  logic [15:0] ack_data = '0;
  logic [15:0] irq_stat;
  logic        busy, err;

  int checks = 0, fails = 0;
  int fires[16];
  int nfire = 0, err_pulses = 0, err_high = 0;
  bit auto_ack = 1'b1, prev_flag = 1'b0, prev_err = 1'b0;

  always #4 clk = ~clk;

  scan_irq_gen i_scan_irq_gen (
    .clk_i(clk), .rst_ni(rst_n), .cycle_i(cyc), .frame_start_i(frame_start),
    .std50_i(std50), .arm_i(arm), .arm_count_i(arm_count), .arm_line_i(arm_line),
    .arm_xoff_i(arm_xoff), .ack_we_i(ack_we), .ack_data_i(ack_data),
    .irq_stat_o(irq_stat), .busy_o(busy), .err_o(err)
  );

  // counter advances just after each rising edge
  initial forever begin
    @(posedge clk);
    #1 cyc = cyc + 1;
  end

  // monitor: records firing time (counter seen at the edge = cyc - 1)
  initial forever begin
    @(negedge clk);
    if (irq_stat[10] && !prev_flag && nfire < 16) begin
      fires[nfire] = int'(cyc) - 1;
      nfire++;
    end
    prev_flag = irq_stat[10];
    if (err) err_high++;
    if (err && !prev_err) err_pulses++;
    prev_err = err;
    if (auto_ack) begin
      ack_we   = irq_stat[10];
      ack_data = 16'h0000;
    end
  end

  function automatic int e_frame(bit m);  return m ? CLK_HZ / 50 : CLK_HZ / 60; endfunction
  function automatic int e_lines(bit m);  return m ? 314 : 263; endfunction
  function automatic int e_line(bit m);   return e_frame(m) / e_lines(m); endfunction
  function automatic int e_first(int base, bit m, int y, int x);
    return base + e_frame(m) + (y * e_frame(m)) / e_lines(m) + x;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic frame_pulse(output int base);
    @(negedge clk);
    frame_start = 1'b1;
    base = int'(cyc);
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic do_arm(bit m, int cnt, int y, int x);
    @(negedge clk);
    std50 = m; arm_count = 8'(cnt); arm_line = 9'(y); arm_xoff = 16'(x);
    arm = 1'b1;
    @(negedge clk);
    arm = 1'b0;
    check(busy == 1'b1, "R4 busy after arm", int'(busy), 1);
  endtask

  task automatic wait_until(int t);
    while (int'(cyc) < t) @(negedge clk);
  endtask

  task automatic run_seq(bit m, int cnt, int y, int x);
    int base, n, t0, l;
    nfire = 0;
    frame_pulse(base);
    do_arm(m, cnt, y, x);
    // R10: scramble command inputs after the arm
    std50 = ~m; arm_count = 8'd7; arm_line = 9'd300; arm_xoff = -16'sd100;
    n  = (cnt == 0) ? 1 : cnt;
    l  = e_line(m);
    t0 = e_first(base, m, y, x);
    wait_until(t0 + (n + 2) * l + 10);
    check(nfire == n, (cnt <= 1) ? "R5 firing count" : "R4 firing count", nfire, n);
    for (int k = 0; k < n && k < nfire; k++)
      check(fires[k] == t0 + k * l,
            (k == 0) ? (m ? "R3,R10 first time" : "R2,R10 first time") : "R4 repeat time",
            fires[k], t0 + k * l);
    check(busy == 1'b0, "R4 busy after last", int'(busy), 0);
  endtask

  initial begin
    int base, t0, ta, tb;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(irq_stat == 16'h0 && busy == 1'b0 && err == 1'b0, "R1 reset state",
          int'({irq_stat, busy, err}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run_seq(1'b0, 3, 10, 37);    // R2 directed
    run_seq(1'b1, 4, 100, 5);    // R3: y*F/314 differs from y*L
    run_seq(1'b0, 0, 0, 0);      // R5 zero count
    run_seq(1'b1, 1, 7, 0);      // R5 count one
    for (int i = 0; i < 5; i++)
      run_seq(1'($urandom_range(0, 1)), int'($urandom_range(0, 4)),
              int'($urandom_range(0, 40)), int'($urandom_range(0, 200)));

    // R6: re-arm after first firing cancels the rest
    nfire = 0;
    frame_pulse(base);
    do_arm(1'b0, 3, 0, 0);
    ta = e_first(base, 1'b0, 0, 0);
    wait_until(ta + 4);
    do_arm(1'b0, 2, 20, 0);
    tb = e_first(base, 1'b0, 20, 0);
    wait_until(tb + 4 * e_line(1'b0));
    check(nfire == 3, "R6 firing count", nfire, 3);
    check(fires[0] == ta, "R6 old first", fires[0], ta);
    check(fires[1] == tb, "R6 new first", fires[1], tb);
    check(fires[2] == tb + e_line(1'b0), "R6 new repeat", fires[2], tb + e_line(1'b0));

    // R9: illegal first event time
    nfire = 0; err_pulses = 0; err_high = 0;
    frame_pulse(base);
    do_arm(1'b0, 2, 0, -6000);
    repeat (80) @(negedge clk);
    check(err_pulses == 1, "R9 err pulse", err_pulses, 1);
    check(err_high == 1, "R9 err width", err_high, 1);
    check(busy == 1'b0, "R9 idle", int'(busy), 0);
    wait_until(base + 7000);
    check(nfire == 0, "R9 no firing", nfire, 0);

    // R7/R8: status write behaviour
    auto_ack = 1'b0;
    ack_we = 1'b0;
    frame_pulse(base);
    do_arm(1'b0, 2, 1, 3);
    t0 = e_first(base, 1'b0, 1, 3);
    while (int'(cyc) != t0) @(negedge clk);
    ack_we = 1'b1; ack_data = 16'h0000;
    @(negedge clk);
    ack_we = 1'b0;
    check(irq_stat == 16'h0400, "R8 set wins", int'(irq_stat), 16'h0400);
    ack_we = 1'b1; ack_data = 16'hFFFF;
    @(negedge clk);
    ack_we = 1'b0;
    check(irq_stat == 16'h0400, "R7 write with bit set", int'(irq_stat), 16'h0400);
    repeat (5) @(negedge clk);
    check(irq_stat == 16'h0400, "R7 flag holds", int'(irq_stat), 16'h0400);
    ack_we = 1'b1; ack_data = 16'hFBFF;
    @(negedge clk);
    ack_we = 1'b0;
    check(irq_stat == 16'h0000, "R7 clear", int'(irq_stat), 0);
    wait_until(t0 + e_line(1'b0) + 2);
    check(irq_stat == 16'h0400, "R4 second firing", int'(irq_stat), 16'h0400);
    ack_we = 1'b1; ack_data = 16'h0000;
    @(negedge clk);
    ack_we = 1'b0;
    check(irq_stat == 16'h0000 && busy == 1'b0, "R7 final clear",
          int'({irq_stat, busy}), 0);
    auto_ack = 1'b1;

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(190000 * 8);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule